// File: doc/BRIEF.md
# MII Management Frame Responder

This block is the management side of an Ethernet PHY, reduced to register form. Instead of clocking management bits serially, the host writes one 32-bit frame word. The block decodes the start, opcode, PHY address and register address fields of that word. It then reads or writes a 32-entry file of 16-bit PHY registers and stores the completed frame back with its completion bit set, so the host can poll for completion and fetch read data.

The register file models the side effects of a basic PHY. A software reset in the control register clears itself and turns auto-negotiation on. A negotiation restart also clears itself, reports negotiation as complete and, when the link input is high, reports link-up together with a 100BASE-TX full-duplex partner. A change on the link input updates the same status bits and raises a 16-bit interrupt status that clears when it is read. A small configuration register sits beside the frame register and has two read-only bits.

Host register selects are 0 for the frame word, 1 for configuration, 2 for interrupt status and 3 for an unused slot that reads zero. Read data appears on `host_rdata` in the cycle after `host_rd`. Every host write takes effect at the clock edge where `host_wr` is sampled.

Top module: `mgmt_frame_engine`

## Requirements
- R1: A frame word whose start field (bits 31:30) is not 2'b01 is stored with bit 16 forced to 1, and no PHY register changes.
- R2: A frame word with a valid start field whose PHY address (bits 27:23) differs from the parameter PHY_ADDR (default 1) is stored with bit 16 forced to 1, and no PHY register changes.
- R3: A serviced frame with opcode (bits 29:28) 2'b01 writes data bits 15:0 into the PHY register selected by bits 22:18. With opcode 2'b10, the stored word keeps bits 31:17, has bit 16 set, and has bits 15:0 replaced by that register's contents.
- R4: A serviced frame with opcode 2'b00 or 2'b11 accesses no PHY register and is stored with bit 16 set and its data field unchanged.
- R5: A write to PHY register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R6: A write to PHY register 0 with bit 9 set stores the value with bit 9 cleared and sets bit 5 of register 1. When link_up is 1, it also sets bit 2 of register 1 and bit 8 of register 5. When link_up is 0, those two bits are left alone.
- R7: The configuration register resets to 32'h0000_0100. A host write to it keeps the previous values of bits 9:8 and takes all other bits from the write data.
- R8: In the cycle after link_up changes, bit 2 of register 1 and bit 8 of register 5 follow the new level, the interrupt status becomes 16'hFFFF, and irq is 1.
- R9: Reading the interrupt status returns its current value and leaves it at zero, with irq at 0, from the next cycle onward.
- R10: After reset, the frame word and interrupt status are 0, irq is 0, register 1 is 16'h4028 with bit 2 added when link_up is 1, register 4 is 16'h0100, register 5 is 16'h0100 when link_up is 1 and 0 otherwise, and registers 2 and 3 hold PHY_ID_HI and PHY_ID_LO.
- R11: All other register addresses, and registers 1 and 5 when written directly, act as plain 16-bit storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select: 0 frame, 1 configuration, 2 interrupt status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data, valid the cycle after host_rd |
| link_up | input | 1 | Link level from the line side |
| irq | output | 1 | High while any interrupt status bit is set |

## Verification
The case that is hardest to reach from the ports is a negotiation restart issued while the link is down, followed by the link coming back up. Only that order shows that the restart leaves the link bits alone and that the later link event alone sets them. The stimulus first drops link_up and drains the interrupt status. It then issues the restart frame and reads registers 1 and 5 through read frames. Finally it raises link_up and reads the same registers again, confirming that the interrupt status is all ones.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  localparam int FRAME_W  = 32;
  localparam int PREG_W   = 16;
  localparam int NPREG    = 32;
  localparam int PREG_AW  = $clog2(NPREG);
  localparam int PHYAD_W  = 5;

  // frame word field positions
  localparam int ST_HI    = 31;
  localparam int OP_HI    = 29;
  localparam int PHY_HI   = 27;
  localparam int RA_HI    = 22;
  localparam int TA_DONE  = 16;

  localparam logic [1:0] ST_VALID = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // PHY register indices
  localparam int R_CTRL = 0;
  localparam int R_STAT = 1;
  localparam int R_ID1  = 2;
  localparam int R_ID2  = 3;
  localparam int R_ADV  = 4;
  localparam int R_LPA  = 5;

  // bit positions inside PHY registers
  localparam int CTRL_SWRST   = 15;
  localparam int CTRL_ANEN    = 12;
  localparam int CTRL_ANRST   = 9;
  localparam int STAT_FD100   = 14;
  localparam int STAT_ANDONE  = 5;
  localparam int STAT_ANABLE  = 3;
  localparam int STAT_LINK    = 2;
  localparam int ABIL_TXFD    = 8;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_ISTAT = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  typedef struct packed {
    logic                serviced;
    logic                do_wr;
    logic                do_rd;
    logic [PREG_AW-1:0]  ra;
    logic [PREG_W-1:0]   data;
  } frame_cmd_t;
endpackage

// File: rtl/mfe_frame_decode.sv
module mfe_frame_decode
  import mfe_pkg::*;
#(
  parameter logic [PHYAD_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic [FRAME_W-1:0] word,
  output frame_cmd_t         cmd
);
  logic [1:0]         st, op;
  logic [PHYAD_W-1:0] pa;

  always_comb begin
    st  = word[ST_HI -: 2];
    op  = word[OP_HI -: 2];
    pa  = word[PHY_HI -: PHYAD_W];
    cmd.serviced = (st == ST_VALID) && (pa == PHY_ADDR);
    cmd.do_wr    = cmd.serviced && (op == OP_WRITE);
    cmd.do_rd    = cmd.serviced && (op == OP_READ);
    cmd.ra       = word[RA_HI -: PREG_AW];
    cmd.data     = word[PREG_W-1:0];
  end
endmodule

// File: rtl/mfe_phy_regs.sv
module mfe_phy_regs
  import mfe_pkg::*;
#(
  parameter logic [PREG_W-1:0] PHY_ID_HI = 16'h0A5B,
  parameter logic [PREG_W-1:0] PHY_ID_LO = 16'h7C30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_up,
  input  logic               we,
  input  logic [PREG_AW-1:0] waddr,
  input  logic [PREG_W-1:0]  wdata,
  input  logic [PREG_AW-1:0] raddr,
  output logic [PREG_W-1:0]  rdata,
  output logic               link_evt
);
  logic [PREG_W-1:0] mem [NPREG];
  logic              link_q;
  logic [PREG_W-1:0] ctrl_val, stat_base, stat_next, lpa_base, lpa_next;
  logic              restart, side_upd;

  function automatic logic [PREG_W-1:0] rst_val(input int idx, input logic lnk);
    logic [PREG_W-1:0] v;
    v = '0;
    case (idx)
      R_STAT: begin
        v[STAT_FD100]  = 1'b1;
        v[STAT_ANDONE] = 1'b1;
        v[STAT_ANABLE] = 1'b1;
        v[STAT_LINK]   = lnk;
      end
      R_ID1: v = PHY_ID_HI;
      R_ID2: v = PHY_ID_LO;
      R_ADV: v[ABIL_TXFD] = 1'b1;
      R_LPA: v[ABIL_TXFD] = lnk;
      default: v = '0;
    endcase
    return v;
  endfunction

  assign link_evt = (link_up != link_q);
  assign restart  = we && (waddr == PREG_AW'(R_CTRL)) && wdata[CTRL_ANRST];
  assign side_upd = restart || link_evt;
  assign rdata    = mem[raddr];

  always_comb begin
    ctrl_val = wdata;
    if (waddr == PREG_AW'(R_CTRL)) begin
      if (wdata[CTRL_SWRST]) begin
        ctrl_val[CTRL_SWRST] = 1'b0;
        ctrl_val[CTRL_ANEN]  = 1'b1;
      end
      ctrl_val[CTRL_ANRST] = 1'b0;
    end
    stat_base = (we && waddr == PREG_AW'(R_STAT)) ? wdata : mem[R_STAT];
    lpa_base  = (we && waddr == PREG_AW'(R_LPA))  ? wdata : mem[R_LPA];
    stat_next = stat_base;
    lpa_next  = lpa_base;
    if (restart) begin
      stat_next[STAT_ANDONE] = 1'b1;
      if (link_up) begin
        stat_next[STAT_LINK] = 1'b1;
        lpa_next[ABIL_TXFD]  = 1'b1;
      end
    end
    if (link_evt) begin
      stat_next[STAT_LINK] = link_up;
      lpa_next[ABIL_TXFD]  = link_up;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q <= link_up;
      for (int i = 0; i < NPREG; i++) mem[i] <= rst_val(i, link_up);
    end else begin
      link_q <= link_up;
      if (we) mem[waddr] <= ctrl_val;
      if (side_upd) begin
        mem[R_STAT] <= stat_next;
        mem[R_LPA]  <= lpa_next;
      end
    end
  end

  // R5: software reset bit never survives into the stored control word
  a_r5_swrst_selfclear: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == PREG_AW'(R_CTRL) && wdata[CTRL_SWRST])
      |=> (!mem[R_CTRL][CTRL_SWRST] && mem[R_CTRL][CTRL_ANEN]));

  // R6: restart reports negotiation complete next cycle
  a_r6_restart_done: assert property (@(posedge clk) disable iff (rst)
    restart |=> (mem[R_STAT][STAT_ANDONE] && !mem[R_CTRL][CTRL_ANRST]));

  // R8: link bits track the line after a change
  a_r8_link_track: assert property (@(posedge clk) disable iff (rst)
    link_evt |=> (mem[R_STAT][STAT_LINK] == $past(link_up)
                  && mem[R_LPA][ABIL_TXFD] == $past(link_up)));
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mfe_pkg::*;
#(
  parameter logic [PHYAD_W-1:0] PHY_ADDR  = 5'd1,
  parameter logic [PREG_W-1:0]  PHY_ID_HI = 16'h0A5B,
  parameter logic [PREG_W-1:0]  PHY_ID_LO = 16'h7C30,
  parameter logic [31:0]        CFG_RST   = 32'h0000_0100,
  parameter logic [31:0]        CFG_RO    = 32'h0000_0300
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        link_up,
  output logic        irq
);
  frame_cmd_t          cmd;
  logic                frame_wr;
  logic [FRAME_W-1:0]  frame_q, frame_next;
  logic [31:0]         cfg_q;
  logic [PREG_W-1:0]   istat_q, istat_next;
  logic [PREG_W-1:0]   preg_rdata;
  logic                link_evt;
  logic [31:0]         rdata_q;
  logic                istat_rd;

  assign frame_wr = host_wr && (host_sel == SEL_FRAME);
  assign istat_rd = host_rd && (host_sel == SEL_ISTAT);

  mfe_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .word (host_wdata),
    .cmd  (cmd)
  );

  mfe_phy_regs #(.PHY_ID_HI(PHY_ID_HI), .PHY_ID_LO(PHY_ID_LO)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .link_up  (link_up),
    .we       (frame_wr && cmd.do_wr),
    .waddr    (cmd.ra),
    .wdata    (cmd.data),
    .raddr    (cmd.ra),
    .rdata    (preg_rdata),
    .link_evt (link_evt)
  );

  always_comb begin
    frame_next = host_wdata;
    if (cmd.do_rd) frame_next[PREG_W-1:0] = preg_rdata;
    frame_next[TA_DONE] = 1'b1;
    istat_next = istat_q;
    if (istat_rd) istat_next = '0;
    if (link_evt) istat_next = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      cfg_q   <= CFG_RST;
      istat_q <= '0;
      irq     <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (frame_wr) frame_q <= frame_next;
      if (host_wr && host_sel == SEL_CFG)
        cfg_q <= (host_wdata & ~CFG_RO) | (cfg_q & CFG_RO);
      istat_q <= istat_next;
      irq     <= |istat_next;
      if (host_rd) begin
        case (host_sel)
          SEL_FRAME: rdata_q <= frame_q;
          SEL_CFG:   rdata_q <= cfg_q;
          SEL_ISTAT: rdata_q <= {16'h0, istat_q};
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign host_rdata = rdata_q;

  // R1: every accepted frame write is marked done
  a_r1_done_flag: assert property (@(posedge clk) disable iff (rst)
    frame_wr |=> frame_q[TA_DONE]);

  // R7: read-only configuration bits hold across host writes
  a_r7_cfg_ro: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel == SEL_CFG) |=> (cfg_q[9:8] == $past(cfg_q[9:8])));

  // R8: a line change raises every interrupt status bit
  a_r8_istat_set: assert property (@(posedge clk) disable iff (rst)
    link_evt |=> (istat_q == 16'hFFFF && irq));

  // R9: reading the status clears it when no line change competes
  a_r9_istat_clear: assert property (@(posedge clk) disable iff (rst)
    (istat_rd && !link_evt) |=> (istat_q == '0 && !irq));
endmodule

// File: tb/mgmt_frame_engine_tb.sv
module mgmt_frame_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        link_up = 1'b1;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  localparam logic [15:0] ID_HI = 16'h0A5B;

  mgmt_frame_engine u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .link_up(link_up), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] mkf(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] pa, input logic [4:0] ra,
                                      input logic [15:0] d);
    return {st, op, pa, ra, 2'b00, d};
  endfunction

  // {frame word, expected read data, read flag, requirement number}
  localparam int NV = 22;
  localparam logic [52:0] VEC [NV] = '{
    {mkf(2'b01,2'b01,5'd1,5'd7, 16'hA5A5), 16'h0000, 1'b0, 4'd3},  // R3 write
    {mkf(2'b01,2'b10,5'd1,5'd7, 16'h0000), 16'hA5A5, 1'b1, 4'd3},  // R3 read
    {mkf(2'b00,2'b01,5'd1,5'd7, 16'h1111), 16'h0000, 1'b0, 4'd1},  // R1 bad start
    {mkf(2'b01,2'b10,5'd1,5'd7, 16'h0000), 16'hA5A5, 1'b1, 4'd1},  // R1 unchanged
    {mkf(2'b01,2'b01,5'd2,5'd7, 16'h2222), 16'h0000, 1'b0, 4'd2},  // R2 other PHY
    {mkf(2'b01,2'b10,5'd1,5'd7, 16'h0000), 16'hA5A5, 1'b1, 4'd2},  // R2 unchanged
    {mkf(2'b01,2'b11,5'd1,5'd7, 16'h3333), 16'h0000, 1'b0, 4'd4},  // R4 opcode 11
    {mkf(2'b01,2'b00,5'd1,5'd7, 16'h4444), 16'h0000, 1'b0, 4'd4},  // R4 opcode 00
    {mkf(2'b01,2'b10,5'd1,5'd7, 16'h0000), 16'hA5A5, 1'b1, 4'd4},  // R4 unchanged
    {mkf(2'b01,2'b10,5'd1,5'd1, 16'h0000), 16'h402C, 1'b1, 4'd10}, // R10 status
    {mkf(2'b01,2'b10,5'd1,5'd4, 16'h0000), 16'h0100, 1'b1, 4'd10}, // R10 advert
    {mkf(2'b01,2'b10,5'd1,5'd5, 16'h0000), 16'h0100, 1'b1, 4'd10}, // R10 partner
    {mkf(2'b01,2'b10,5'd1,5'd2, 16'h0000), ID_HI,    1'b1, 4'd10}, // R10 id
    {mkf(2'b01,2'b01,5'd1,5'd0, 16'h8000), 16'h0000, 1'b0, 4'd5},  // R5 sw reset
    {mkf(2'b01,2'b10,5'd1,5'd0, 16'h0000), 16'h1000, 1'b1, 4'd5},  // R5 result
    {mkf(2'b01,2'b01,5'd1,5'd1, 16'h0000), 16'h0000, 1'b0, 4'd11}, // R11 clear stat
    {mkf(2'b01,2'b10,5'd1,5'd1, 16'h0000), 16'h0000, 1'b1, 4'd11}, // R11 stat read
    {mkf(2'b01,2'b01,5'd1,5'd0, 16'h0200), 16'h0000, 1'b0, 4'd6},  // R6 restart
    {mkf(2'b01,2'b10,5'd1,5'd0, 16'h0000), 16'h0000, 1'b1, 4'd6},  // R6 ctrl
    {mkf(2'b01,2'b10,5'd1,5'd1, 16'h0000), 16'h0024, 1'b1, 4'd6},  // R6 stat
    {mkf(2'b01,2'b01,5'd1,5'd31,16'hFFFF), 16'h0000, 1'b0, 4'd11}, // R11 top addr
    {mkf(2'b01,2'b10,5'd1,5'd31,16'h0000), 16'hFFFF, 1'b1, 4'd11}  // R11 readback
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_sel = sel;
    @(posedge clk);
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic phy_read(input logic [4:0] ra, output logic [15:0] d);
    logic [31:0] r;
    hwrite(2'd0, mkf(2'b01, 2'b10, 5'd1, ra, 16'h0));
    hread(2'd0, r);
    d = r[15:0];
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state of host-visible registers
    check("R10 irq", {31'h0, irq}, 32'h0);
    hread(2'd0, r); check("R10 frame", r, 32'h0);
    hread(2'd2, r); check("R10 istat", r, 32'h0);
    // R7 configuration reset value
    hread(2'd1, r); check("R7 cfg reset", r, 32'h0000_0100);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] w, e;
      w = VEC[i][52:21];
      e = w | 32'h0001_0000;
      if (VEC[i][4]) e = {w[31:17], 1'b1, VEC[i][20:5]};
      hwrite(2'd0, w);
      hread(2'd0, r);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), r, e);
    end

    // R7 read-only bits keep their values
    hwrite(2'd1, 32'hFFFF_FFFF);
    hread(2'd1, r); check("R7 cfg ones", r, 32'hFFFF_FDFF);
    hwrite(2'd1, 32'h0000_0000);
    hread(2'd1, r); check("R7 cfg zeros", r, 32'h0000_0100);

    // R8 link falls
    @(negedge clk); link_up = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 irq after link down", {31'h0, irq}, 32'h1);
    phy_read(5'd1, p); check("R8 stat link down", {16'h0, p}, 32'h0020);
    phy_read(5'd5, p); check("R8 partner link down", {16'h0, p}, 32'h0000);
    // R9 read returns then clears
    hread(2'd2, r); check("R9 istat value", r, 32'h0000_FFFF);
    hread(2'd2, r); check("R9 istat cleared", r, 32'h0);
    check("R9 irq low", {31'h0, irq}, 32'h0);

    // R6 restart with link down leaves link bits clear
    hwrite(2'd0, mkf(2'b01, 2'b01, 5'd1, 5'd0, 16'h0200));
    phy_read(5'd1, p); check("R6 stat restart link down", {16'h0, p}, 32'h0020);
    phy_read(5'd5, p); check("R6 partner restart link down", {16'h0, p}, 32'h0000);
    check("R6 no irq from restart", {31'h0, irq}, 32'h0);

    // R8 link rises afterwards
    @(negedge clk); link_up = 1'b1;
    @(negedge clk); @(negedge clk);
    phy_read(5'd1, p); check("R8 stat link up", {16'h0, p}, 32'h0024);
    phy_read(5'd5, p); check("R8 partner link up", {16'h0, p}, 32'h0100);
    hread(2'd2, r); check("R8 istat all ones", r, 32'h0000_FFFF);
    check("R9 irq cleared again", {31'h0, irq}, 32'h0);

    // R10 reset with link down leaves link bits clear
    @(negedge clk); link_up = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    phy_read(5'd1, p); check("R10 stat no link", {16'h0, p}, 32'h4028);
    phy_read(5'd5, p); check("R10 partner no link", {16'h0, p}, 32'h0000);
    check("R10 irq after reset", {31'h0, irq}, 32'h0);

    finish_run();
  end
endmodule